// File: doc/BRIEF.md
# Message-Committed Discrete Output Latches

This block connects the word-transfer port of a serial-bus terminal to a bank of discrete outputs and buffered discrete inputs, with no host processor in between. The terminal presents a linear address with chip select and write or read qualifiers. The address is decoded into one write strobe per output register and one read strobe per input buffer.

Each output register has two stages. The capture stage takes every received data word as the terminal transfers it. The visible stage copies from the capture stage only when the terminal reports that the whole message arrived intact. If any word in a message carried an error, nothing from that message reaches the outputs. Read strobes place the selected discrete input word onto the shared data bus. A drive-enable output marks the cycles in which the bus is driven, so the data bus can be shared with other agents through a tri-state buffer.

A message is bracketed by a `msg_start` pulse and a `good_blk` pulse. Reset is asserted asynchronously. Its release is synchronised to the clock.

Top module: `msg_commit_latches`

## Requirements
- R1: While `rst_n` is low, `dout` is all zeros and `rdata_oe` is low. After `rst_n` rises, the block accepts transfers from the third rising clock edge onward.
- R2: A transfer with `cs` and `wr` high and `addr` below NUM_OUT loads `wdata` into the capture stage of register `addr`. A write does not change `dout` by itself.
- R3: A `good_blk` pulse in a message with no word error copies every register written in that message to its slice of `dout` (register i at bits [16*i+15:16*i]). All the copies happen on the same clock edge, so the new values are visible one cycle after the pulse.
- R4: On a commit, a register that was not written during the message keeps its previous `dout` value.
- R5: `word_err` high during an accepted write marks the message as bad. A `good_blk` in a bad message leaves `dout` unchanged.
- R6: `msg_start` clears the bad-message mark, so a later clean message commits normally.
- R7: Words captured in a rejected message are never committed by a later message that did not rewrite those registers.
- R8: Words captured before a `msg_start` that had no `good_blk` in between are discarded in the same way.
- R9: With `cs` and `rd` high and `addr` below NUM_IN, `rdata_oe` is high and `rdata` equals input word `addr` of `din` in the same cycle. Otherwise `rdata_oe` is low and `rdata` is zero.
- R10: A write with `cs` low, or with `addr` at or above NUM_OUT, is ignored. It changes no register, and a `word_err` on such a cycle does not mark the message as bad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| cs | input | 1 | Chip select qualifying every transfer |
| wr | input | 1 | Write qualifier |
| rd | input | 1 | Read qualifier |
| addr | input | ADDR_W (3) | Linear register address |
| wdata | input | DATA_W (16) | Received data word |
| word_err | input | 1 | Error flag for the word being written |
| msg_start | input | 1 | Pulse marking the start of a message |
| good_blk | input | 1 | Pulse marking that the message was received intact |
| din | input | NUM_IN*DATA_W (80) | Discrete input words |
| dout | output | NUM_OUT*DATA_W (96) | Committed discrete outputs |
| rdata | output | DATA_W (16) | Read data for the shared bus |
| rdata_oe | output | 1 | Bus drive enable |

## Verification
The bench goes after the cases where capture and commit can drift apart:
- A message that is rejected and then followed by a message touching other registers. A design that forgot to clear its written flags would release the rejected words here.
- A message abandoned by a fresh `msg_start` with no `good_blk`, which stresses the same flags.
- A clean message that follows a bad one. A design whose error mark never clears would freeze `dout` from then on.
- Writes to unselected or out-of-range addresses, with `word_err` raised. A sloppy decoder would corrupt a register or poison the message.

Random messages with sparse errors, checked against a reference model, cover ordinary commits and reads.

// File: rtl/msgl_pkg.sv
package msgl_pkg;
  localparam int unsigned WORD_W = 16;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/msgl_rst_sync.sv
module msgl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/msgl_decode.sv
module msgl_decode #(
  parameter int unsigned NUM_OUT = 6,
  parameter int unsigned NUM_IN  = 5,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               srst_n,
  input  logic               cs,
  input  logic               wr,
  input  logic               rd,
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_OUT-1:0] wr_strb,
  output logic [NUM_IN-1:0]  rd_strb
);
  logic wr_req;
  logic rd_req;

  assign wr_req = cs & wr;
  assign rd_req = cs & rd;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_wr
    assign wr_strb[i] = wr_req && (addr == ADDR_W'(i));
  end

  for (genvar j = 0; j < NUM_IN; j++) begin : g_rd
    assign rd_strb[j] = rd_req && (addr == ADDR_W'(j));
  end

  // R2
  wr_strb_onehot_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0(wr_strb));

  // R10
  wr_needs_cs_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (|wr_strb) |-> (cs && wr));

  // R9
  rd_strb_onehot_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0(rd_strb));
endmodule

// File: rtl/msgl_stage_bank.sv
module msgl_stage_bank #(
  parameter int unsigned NUM_OUT = 6,
  parameter int unsigned DATA_W  = 16
) (
  input  logic                      clk,
  input  logic                      srst_n,
  input  logic [NUM_OUT-1:0]        wr_strb,
  input  logic [DATA_W-1:0]         wdata,
  input  logic                      word_err,
  input  logic                      msg_start,
  input  logic                      good_blk,
  output logic [NUM_OUT*DATA_W-1:0] dout
);
  logic [NUM_OUT-1:0] wflag_q, wflag_d;
  logic               bad_q, bad_d;
  logic               xfer;
  logic               commit;
  logic [DATA_W-1:0]  cap_q [NUM_OUT];
  logic [DATA_W-1:0]  cap_d [NUM_OUT];
  logic [DATA_W-1:0]  vis_q [NUM_OUT];
  logic [DATA_W-1:0]  vis_d [NUM_OUT];

  assign xfer   = |wr_strb;
  assign commit = good_blk & ~bad_q;

  always_comb begin
    if (msg_start) bad_d = xfer & word_err;
    else           bad_d = bad_q | (xfer & word_err);
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_reg
    always_comb begin
      wflag_d[i] = wflag_q[i];
      if (msg_start || good_blk) wflag_d[i] = 1'b0;
      if (wr_strb[i])            wflag_d[i] = 1'b1;
      cap_d[i] = wr_strb[i] ? wdata : cap_q[i];
      vis_d[i] = (commit && wflag_q[i]) ? cap_q[i] : vis_q[i];
    end

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) begin
        cap_q[i] <= '0;
        vis_q[i] <= '0;
      end else begin
        if (wr_strb[i])              cap_q[i] <= cap_d[i];
        if (commit && wflag_q[i])    vis_q[i] <= vis_d[i];
      end
    end

    assign dout[i*DATA_W +: DATA_W] = vis_q[i];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      wflag_q <= '0;
      bad_q   <= 1'b0;
    end else begin
      wflag_q <= wflag_d;
      bad_q   <= bad_d;
    end
  end

  // R2
  dout_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !good_blk |=> $stable(dout));

  // R5
  bad_msg_block_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (good_blk && bad_q) |=> $stable(dout));

  // R7
  flags_clear_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (good_blk && !xfer) |=> (wflag_q == '0));

  // R6
  bad_clear_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (msg_start && !(xfer && word_err)) |=> !bad_q);
endmodule

// File: rtl/msgl_read_mux.sv
module msgl_read_mux #(
  parameter int unsigned NUM_IN = 5,
  parameter int unsigned DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     srst_n,
  input  logic [NUM_IN-1:0]        rd_strb,
  input  logic [NUM_IN*DATA_W-1:0] din,
  output logic [DATA_W-1:0]        rdata,
  output logic                     rdata_oe
);
  always_comb begin
    rdata = '0;
    for (int k = 0; k < NUM_IN; k++) begin
      if (rd_strb[k]) rdata = rdata | din[k*DATA_W +: DATA_W];
    end
  end

  assign rdata_oe = |rd_strb;

  // R9
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !rdata_oe |-> (rdata == '0));
endmodule

// File: rtl/msg_commit_latches.sv
module msg_commit_latches #(
  parameter int unsigned NUM_OUT = 6,
  parameter int unsigned NUM_IN  = 5,
  parameter int unsigned DATA_W  = msgl_pkg::WORD_W,
  localparam int unsigned ADDR_W = $clog2(msgl_pkg::max2(NUM_OUT, NUM_IN))
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs,
  input  logic                      wr,
  input  logic                      rd,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic                      word_err,
  input  logic                      msg_start,
  input  logic                      good_blk,
  input  logic [NUM_IN*DATA_W-1:0]  din,
  output logic [NUM_OUT*DATA_W-1:0] dout,
  output logic [DATA_W-1:0]         rdata,
  output logic                      rdata_oe
);
  logic               srst_n;
  logic [NUM_OUT-1:0] wr_strb;
  logic [NUM_IN-1:0]  rd_strb;

  msgl_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  msgl_decode #(.NUM_OUT(NUM_OUT), .NUM_IN(NUM_IN), .ADDR_W(ADDR_W)) u_dec (
    .clk     (clk),
    .srst_n  (srst_n),
    .cs      (cs),
    .wr      (wr),
    .rd      (rd),
    .addr    (addr),
    .wr_strb (wr_strb),
    .rd_strb (rd_strb)
  );

  msgl_stage_bank #(.NUM_OUT(NUM_OUT), .DATA_W(DATA_W)) u_bank (
    .clk       (clk),
    .srst_n    (srst_n),
    .wr_strb   (wr_strb),
    .wdata     (wdata),
    .word_err  (word_err),
    .msg_start (msg_start),
    .good_blk  (good_blk),
    .dout      (dout)
  );

  msgl_read_mux #(.NUM_IN(NUM_IN), .DATA_W(DATA_W)) u_rmux (
    .clk      (clk),
    .srst_n   (srst_n),
    .rd_strb  (rd_strb),
    .din      (din),
    .rdata    (rdata),
    .rdata_oe (rdata_oe)
  );

  // R9
  oe_qualified_chk: assert property (@(posedge clk) disable iff (!srst_n)
    rdata_oe |-> (cs && rd));
endmodule

// File: tb/msg_commit_latches_bench.sv
module msg_commit_latches_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NO = 6;
  localparam int NI = 5;
  localparam int DW = 16;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 0, wr = 0, rd = 0, word_err = 0, msg_start = 0, good_blk = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [NI*DW-1:0] din = '0;
  logic [NO*DW-1:0] dout;
  logic [DW-1:0] rdata;
  logic rdata_oe;

  int n_chk = 0;
  int n_bad = 0;

  logic [DW-1:0] m_cap [NO];
  logic [DW-1:0] m_vis [NO];
  logic          m_flag [NO];
  logic          m_bad;

  always #(CLK_PERIOD/2) clk = ~clk;

  msg_commit_latches u_msg_commit_latches (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .addr(addr),
    .wdata(wdata), .word_err(word_err), .msg_start(msg_start),
    .good_blk(good_blk), .din(din), .dout(dout), .rdata(rdata),
    .rdata_oe(rdata_oe)
  );

  function automatic logic [DW-1:0] exp_read(input int a);
    return (a < NI) ? din[a*DW +: DW] : '0;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < NO; i++) check(req, dout[i*DW +: DW], m_vis[i]);
  endtask

  task automatic idle();
    cs = 0; wr = 0; rd = 0; word_err = 0; msg_start = 0; good_blk = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic start_msg();
    msg_start = 1;
    m_bad = 1'b0;
    for (int i = 0; i < NO; i++) m_flag[i] = 1'b0;
    step();
  endtask

  task automatic wr_word(input logic c, input int a, input logic [DW-1:0] d, input logic e);
    cs = c; wr = 1; addr = AW'(a); wdata = d; word_err = e;
    if (c && a < NO) begin
      m_cap[a] = d;
      m_flag[a] = 1'b1;
      if (e) m_bad = 1'b1;
    end
    step();
  endtask

  task automatic end_msg();
    good_blk = 1;
    if (!m_bad)
      for (int i = 0; i < NO; i++) if (m_flag[i]) m_vis[i] = m_cap[i];
    for (int i = 0; i < NO; i++) m_flag[i] = 1'b0;
    step();
  endtask

  task automatic rd_word(input logic c, input int a, input string req);
    cs = c; rd = 1; addr = AW'(a);
    #1;
    check(req, {15'd0, rdata_oe}, {15'd0, (c && a < NI)});
    check(req, rdata, c ? exp_read(a) : '0);
    step();
  endtask

  initial begin
    for (int i = 0; i < NO; i++) begin
      m_cap[i] = '0; m_vis[i] = '0; m_flag[i] = 1'b0;
    end
    m_bad = 1'b0;
    void'($urandom(32'h5eed_1234));
    #3;
    check_all("R1");
    check("R1", {15'd0, rdata_oe}, 16'd0);
    @(negedge clk); rst_n = 1;
    step(); step(); step();

    // R3, R4: clean message on regs 0 and 3
    start_msg();
    wr_word(1, 0, 16'hA001, 0);
    wr_word(1, 3, 16'hA003, 0);
    check_all("R2");
    end_msg();
    check_all("R3");
    start_msg();
    wr_word(1, 1, 16'hB001, 0);
    end_msg();
    check_all("R4");

    // R5, R7: rejected message, then clean message on another reg
    start_msg();
    wr_word(1, 0, 16'hDEAD, 0);
    wr_word(1, 2, 16'hBEEF, 1);
    end_msg();
    check_all("R5");
    start_msg();
    wr_word(1, 4, 16'hC004, 0);
    end_msg();
    check_all("R7");
    check("R6", dout[4*DW +: DW], 16'hC004);

    // R8: abandoned message
    start_msg();
    wr_word(1, 5, 16'h5555, 0);
    start_msg();
    wr_word(1, 1, 16'hD001, 0);
    end_msg();
    check_all("R8");

    // R10: ignored writes with error
    start_msg();
    wr_word(0, 0, 16'hFFFF, 1);
    wr_word(1, 6, 16'hEEEE, 1);
    wr_word(1, 7, 16'hEEEE, 1);
    wr_word(1, 2, 16'hE002, 0);
    end_msg();
    check_all("R10");
    check("R10", dout[0 +: DW], 16'hA001);

    // R9: reads
    din = {16'h4444, 16'h3333, 16'h2222, 16'h1111, 16'h0F0F};
    for (int a = 0; a < 8; a++) rd_word(1, a, "R9");
    rd_word(0, 1, "R9");

    // random messages
    for (int m = 0; m < 200; m++) begin
      start_msg();
      for (int w = 0; w < 1 + ($urandom % 6); w++) begin
        int r;
        r = $urandom % 100;
        if (r < 15) begin
          din[($urandom % NI)*DW +: DW] = DW'($urandom);
          rd_word(1, $urandom % 8, "R9");
        end else begin
          wr_word((r % 10) != 0, $urandom % 8, DW'($urandom), ($urandom % 20) == 0);
        end
      end
      if (($urandom % 8) != 0) end_msg();
      check_all("R3");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule